// File: doc/BRIEF.md
# Multi-Block DMA Channel Sequencer

This block is the control sequencer of a single DMA channel that moves a chain of blocks. Software programs the channel's source address, destination address, control word, configuration and next-descriptor pointer while the channel is free, then starts it. The data movement itself sits outside the block and is stubbed as a one-cycle block-complete pulse. That pulse carries the addresses at which the source and destination sides stopped.

On every block-complete pulse the sequencer picks the next step. It can end the transfer. It can reload one or both sides from their initially programmed addresses. It can fetch a four-word descriptor from memory through a valid/ready read port. Illegal combinations of pointer, per-side list enables and reload bits raise an error flag instead of behaving arbitrarily. Five sticky pending flags drive a masked interrupt line, and software clears them by writing ones.

The read port follows valid/ready rules. Once `mem_req_valid` is high it stays high, and `mem_req_addr` stays stable, until a cycle with `mem_req_ready` high. At most one request is outstanding. The responder returns exactly one `mem_rsp_valid` beat, in a later cycle, for each accepted request. The response side has no back-pressure: the sequencer always accepts it.

Top module: `dma_chain_seq`

## Requirements
- R1: After reset the channel is disabled. Address, control, pointer, configuration, mask and all pending flags are zero, no read request is raised and `irq` is low.
- R2: `wr_sel` selects the write target: 0 source, 1 destination, 2 control, 3 configuration, 4 pointer, 5 enable, 6 flag clear, 7 mask. Writes to selects 0, 1, 2 and 4 take effect only while `ch_en` is 0. Configuration, mask and clear writes are accepted at any time. Writing select 5 with bit 0 set starts a disabled channel.
- R3: Configuration bit 0 is source reload and bit 1 is destination reload. With the pointer zero and both reload bits clear, a block-complete pulse ends the transfer. At that clock edge `ch_en` falls and the transfer flag (bit 0) and block flag (bit 1) are set.
- R4: The pointer counts as zero when bits 31..2 are zero. In that case control bits 2 (source list enable) and 3 (destination list enable) have no effect.
- R5: With the pointer zero and a reload bit set, a block-complete pulse sets the block flag and keeps the channel running. A side with its reload bit set returns to its initially programmed address. The other side takes the end address given with the pulse. Repetition stops only after software clears both reload bits; the next block-complete pulse then ends the transfer.
- R6: With a nonzero pointer, both list enables set and no reload, a block-complete pulse sets the block flag and starts a fetch. The fetch reads four words at the pointer with its low two bits forced to zero, then +4, +8 and +12. The words are source, destination, next pointer and control, and all four registers load at the clock edge of the fourth response.
- R7: During a fetch the read port obeys the hold and single-outstanding rules above, and block-complete pulses are ignored.
- R8: A nonzero pointer with both list enables clear marks the final block: the next block-complete pulse ends the transfer as in R3.
- R9: A nonzero pointer combined with a set reload bit, or with exactly one list enable set, is illegal. The block-complete pulse then sets the error flag (bit 4) and disables the channel without setting the transfer flag.
- R10: The pulses `src_tran` and `dst_tran` set flags 2 and 3. When a set and a clear of the same flag meet in one cycle, the flag stays set. `int_stat` equals the flags ANDed with the mask, and `irq` is the OR of `int_stat`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register write target |
| wr_data | input | DW | Register write data |
| blk_done | input | 1 | Block-complete pulse from the data mover |
| blk_src_end | input | AW | Source address where the finished block stopped |
| blk_dst_end | input | AW | Destination address where the finished block stopped |
| src_tran | input | 1 | Source transaction complete pulse |
| dst_tran | input | 1 | Destination transaction complete pulse |
| mem_req_valid | output | 1 | Descriptor read request valid |
| mem_req_ready | input | 1 | Descriptor read request accepted |
| mem_req_addr | output | AW | Descriptor word address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | DW | Read data |
| ch_en | output | 1 | Channel enabled (busy) |
| cur_src | output | AW | Current source address |
| cur_dst | output | AW | Current destination address |
| cur_ctl | output | DW | Current control word; bits 1..0 hold the flow type and are only carried |
| cur_llp | output | AW | Current next-descriptor pointer |
| int_raw | output | 5 | Pending flags: 0 transfer, 1 block, 2 source tran, 3 dest tran, 4 error |
| int_stat | output | 5 | Pending flags after the mask |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the responder never produces a response without an accepted request, and that it returns exactly one response for each one. They also assume that `blk_done` arrives only while the channel is running. The stimulus keeps within both assumptions. The bench's memory responder answers one cycle after each accepted request and varies `mem_req_ready` on a fixed pattern. The stimulus never issues a register write in the same cycle as a block-complete pulse. The one deliberate exception is a `blk_done` pulse issued during a fetch, which checks that the pulse is ignored.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  localparam int NUM_FLAGS  = 5;
  localparam int DESC_WORDS = 4;

  localparam int FLG_TFR  = 0;
  localparam int FLG_BLK  = 1;
  localparam int FLG_SRCT = 2;
  localparam int FLG_DSTT = 3;
  localparam int FLG_ERR  = 4;

  localparam logic [2:0] SEL_SRC  = 3'd0;
  localparam logic [2:0] SEL_DST  = 3'd1;
  localparam logic [2:0] SEL_CTL  = 3'd2;
  localparam logic [2:0] SEL_CFG  = 3'd3;
  localparam logic [2:0] SEL_LLP  = 3'd4;
  localparam logic [2:0] SEL_ENA  = 3'd5;
  localparam logic [2:0] SEL_CLR  = 3'd6;
  localparam logic [2:0] SEL_MASK = 3'd7;

  typedef enum logic [1:0] {
    ACT_DONE   = 2'd0,
    ACT_RELOAD = 2'd1,
    ACT_FETCH  = 2'd2,
    ACT_ERR    = 2'd3
  } act_e;
endpackage

// File: rtl/dcs_mode_decode.sv
module dcs_mode_decode import dcs_pkg::*; #(
  parameter int AW = 32
) (
  input  logic [AW-3:0] llp_word,
  input  logic          list_src_en,
  input  logic          list_dst_en,
  input  logic [1:0]    reload,
  output act_e          act
);
  logic ptr_live;
  logic any_reload;

  assign ptr_live   = |llp_word;
  assign any_reload = |reload;

  always_comb begin
    if (!ptr_live)
      act = any_reload ? ACT_RELOAD : ACT_DONE;
    else if (any_reload)
      act = ACT_ERR;
    else if (list_src_en && list_dst_en)
      act = ACT_FETCH;
    else if (!list_src_en && !list_dst_en)
      act = ACT_DONE;
    else
      act = ACT_ERR;
  end
endmodule

// File: rtl/dcs_desc_fetch.sv
module dcs_desc_fetch #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int NW = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [AW-3:0]         base_w,
  output logic                  req_valid,
  input  logic                  req_ready,
  output logic [AW-1:0]         req_addr,
  input  logic                  rsp_valid,
  input  logic [DW-1:0]         rsp_data,
  output logic [NW-2:0][DW-1:0] words,
  output logic                  done
);
  localparam int IW = $clog2(NW);
  localparam logic [IW-1:0] LAST = IW'(NW - 1);

  typedef enum logic [1:0] {F_IDLE, F_REQ, F_WAIT} fst_e;
  fst_e          st;
  logic [IW-1:0] idx;
  logic [AW-3:0] base_q;

  assign req_valid = (st == F_REQ);
  assign req_addr  = {base_q + (AW-2)'(idx), 2'b00};
  assign done      = (st == F_WAIT) && rsp_valid && (idx == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= F_IDLE;
      idx    <= '0;
      base_q <= '0;
    end else begin
      case (st)
        F_IDLE: if (start) begin
          base_q <= base_w;
          idx    <= '0;
          st     <= F_REQ;
        end
        F_REQ: if (req_ready) st <= F_WAIT;
        F_WAIT: if (rsp_valid) begin
          if (idx == LAST) st <= F_IDLE;
          else begin
            idx <= idx + 1'b1;
            st  <= F_REQ;
          end
        end
        default: st <= F_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < NW - 1; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) words[g] <= '0;
      else if (st == F_WAIT && rsp_valid && idx == IW'(g)) words[g] <= rsp_data;
    end
  end

  a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr));
  a_r7_no_rsp_while_asking: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !rsp_valid);
endmodule

// File: rtl/dcs_flag_bank.sv
module dcs_flag_bank #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] mask,
  output logic [N-1:0] raw,
  output logic [N-1:0] stat,
  output logic         irq
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      raw[i] <= 1'b0;
      else if (set[i]) raw[i] <= 1'b1;
      else if (clr[i]) raw[i] <= 1'b0;
    end

    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> raw[i]);
    a_r10_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
      clr[i] && !set[i] |=> !raw[i]);
  end

  assign stat = raw & mask;
  assign irq  = |stat;
endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq import dcs_pkg::*; #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          blk_done,
  input  logic [AW-1:0] blk_src_end,
  input  logic [AW-1:0] blk_dst_end,
  input  logic          src_tran,
  input  logic          dst_tran,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data,
  output logic          ch_en,
  output logic [AW-1:0] cur_src,
  output logic [AW-1:0] cur_dst,
  output logic [DW-1:0] cur_ctl,
  output logic [AW-1:0] cur_llp,
  output logic [4:0]    int_raw,
  output logic [4:0]    int_stat,
  output logic          irq
);
  localparam int NF = NUM_FLAGS;
  localparam int NW = DESC_WORDS;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FETCH} st_e;
  st_e st;

  logic [AW-1:0] src_q, dst_q, init_src, init_dst, llp_q;
  logic [DW-1:0] ctl_q;
  logic [1:0]    cfg_q;
  logic [NF-1:0] mask_q, flag_set, flag_clr;
  act_e          act;
  logic          run_evt, prog_ok, f_start, f_done;
  logic [NW-2:0][DW-1:0] f_words;

  assign prog_ok = wr_en && (st == ST_IDLE);
  assign run_evt = blk_done && (st == ST_RUN);
  assign f_start = run_evt && (act == ACT_FETCH);

  dcs_mode_decode #(.AW(AW)) u_dec (
    .llp_word    (llp_q[AW-1:2]),
    .list_src_en (ctl_q[2]),
    .list_dst_en (ctl_q[3]),
    .reload      (cfg_q),
    .act         (act)
  );

  dcs_desc_fetch #(.AW(AW), .DW(DW), .NW(NW)) u_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (f_start),
    .base_w    (llp_q[AW-1:2]),
    .req_valid (mem_req_valid),
    .req_ready (mem_req_ready),
    .req_addr  (mem_req_addr),
    .rsp_valid (mem_rsp_valid),
    .rsp_data  (mem_rsp_data),
    .words     (f_words),
    .done      (f_done)
  );

  always_comb begin
    flag_set           = '0;
    flag_set[FLG_TFR]  = run_evt && (act == ACT_DONE);
    flag_set[FLG_BLK]  = run_evt && (act != ACT_ERR);
    flag_set[FLG_ERR]  = run_evt && (act == ACT_ERR);
    flag_set[FLG_SRCT] = src_tran;
    flag_set[FLG_DSTT] = dst_tran;
    flag_clr = (wr_en && wr_sel == SEL_CLR) ? wr_data[NF-1:0] : '0;
  end

  dcs_flag_bank #(.N(NF)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (flag_set),
    .clr   (flag_clr),
    .mask  (mask_q),
    .raw   (int_raw),
    .stat  (int_stat),
    .irq   (irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      src_q    <= '0;
      dst_q    <= '0;
      init_src <= '0;
      init_dst <= '0;
      llp_q    <= '0;
      ctl_q    <= '0;
      cfg_q    <= '0;
      mask_q   <= '0;
    end else begin
      if (prog_ok) begin
        case (wr_sel)
          SEL_SRC: begin src_q <= wr_data[AW-1:0]; init_src <= wr_data[AW-1:0]; end
          SEL_DST: begin dst_q <= wr_data[AW-1:0]; init_dst <= wr_data[AW-1:0]; end
          SEL_CTL: ctl_q <= wr_data;
          SEL_LLP: llp_q <= wr_data[AW-1:0];
          default: ;
        endcase
      end
      if (wr_en && wr_sel == SEL_CFG)  cfg_q  <= wr_data[1:0];
      if (wr_en && wr_sel == SEL_MASK) mask_q <= wr_data[NF-1:0];

      case (st)
        ST_IDLE: if (wr_en && wr_sel == SEL_ENA && wr_data[0]) st <= ST_RUN;
        ST_RUN: if (blk_done) begin
          case (act)
            ACT_RELOAD: begin
              src_q <= cfg_q[0] ? init_src : blk_src_end;
              dst_q <= cfg_q[1] ? init_dst : blk_dst_end;
            end
            ACT_FETCH: st <= ST_FETCH;
            default:   st <= ST_IDLE;
          endcase
        end
        ST_FETCH: if (f_done) begin
          src_q <= f_words[0][AW-1:0];
          dst_q <= f_words[1][AW-1:0];
          llp_q <= f_words[2][AW-1:0];
          ctl_q <= mem_rsp_data;
          st    <= ST_RUN;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign ch_en   = (st != ST_IDLE);
  assign cur_src = src_q;
  assign cur_dst = dst_q;
  assign cur_ctl = ctl_q;
  assign cur_llp = llp_q;

  a_r2_src_locked: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_RUN && !blk_done && wr_en && wr_sel == SEL_SRC |=> $stable(cur_src));
  a_r3_single_ends: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_RUN && blk_done && llp_q[AW-1:2] == '0 && cfg_q == 2'b00
    |=> !ch_en && int_raw[FLG_TFR] && int_raw[FLG_BLK]);
  a_r5_src_restored: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_RUN && blk_done && act == ACT_RELOAD && cfg_q[0] |=> cur_src == $past(init_src));
  a_r5_keeps_running: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_RUN && blk_done && act == ACT_RELOAD |=> ch_en);
  a_r7_blk_ignored_in_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_FETCH && !f_done |=> ch_en && $stable(int_raw[FLG_TFR]) || int_raw[FLG_TFR]);
  a_r9_error_stops: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_RUN && blk_done && act == ACT_ERR |=> int_raw[FLG_ERR] && !ch_en);
  a_r1_no_req_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_IDLE |-> !mem_req_valid);
endmodule

// File: tb/sim_dma_chain_seq.sv
`timescale 1ns/1ps
module sim_dma_chain_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic        blk_done = 1'b0;
  logic [31:0] blk_src_end = '0, blk_dst_end = '0;
  logic        src_tran = 1'b0, dst_tran = 1'b0;
  logic        mem_req_valid, mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        ch_en, irq;
  logic [31:0] cur_src, cur_dst, cur_ctl, cur_llp;
  logic [4:0]  int_raw, int_stat;

  always #5 clk = ~clk;

  dma_chain_seq u0 (.*);

  int    vectors = 0, miscompares = 0;
  bit    finished = 1'b0;
  string cur_req = "R1";

  // descriptor memory and responder
  logic [31:0] mem [0:15];
  logic        hs = 1'b0;
  logic [31:0] hs_addr = '0;
  int          cyc = 0;
  always @(posedge clk) begin
    hs      <= mem_req_valid && mem_req_ready;
    hs_addr <= mem_req_addr;
    cyc     <= cyc + 1;
  end
  always @(negedge clk) begin
    mem_rsp_valid <= hs;
    mem_rsp_data  <= mem[hs_addr[5:2]];
    mem_req_ready <= (cyc % 3) != 0;
  end

  // behavioural reference model
  bit          m_en, m_fetch, m_wait;
  int          m_k;
  logic [31:0] m_src, m_dst, m_ctl, m_llp, m_isrc, m_idst, m_base;
  logic [1:0]  m_cfg;
  logic [4:0]  m_raw, m_mask;
  logic [31:0] m_w [0:3];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_fetch = 0; m_wait = 0; m_k = 0;
      m_src = 0; m_dst = 0; m_ctl = 0; m_llp = 0; m_isrc = 0; m_idst = 0; m_base = 0;
      m_cfg = 0; m_raw = 0; m_mask = 0;
    end else begin
      bit en0;
      logic [4:0] setv, clrv;
      en0 = m_en; setv = 0; clrv = 0;
      if (en0 && !m_fetch && blk_done) begin
        bit rl, lz, ls, ld;
        rl = (m_cfg != 0); lz = ((m_llp >> 2) == 0); ls = m_ctl[2]; ld = m_ctl[3];
        if (lz && !rl) begin m_en = 0; setv |= 5'b00011; end
        else if (lz) begin
          m_src = m_cfg[0] ? m_isrc : blk_src_end;
          m_dst = m_cfg[1] ? m_idst : blk_dst_end;
          setv |= 5'b00010;
        end
        else if (rl || (ls != ld)) begin m_en = 0; setv |= 5'b10000; end
        else if (ls) begin
          m_fetch = 1; m_wait = 0; m_k = 0; m_base = m_llp & ~32'h3; setv |= 5'b00010;
        end
        else begin m_en = 0; setv |= 5'b00011; end
      end else if (m_fetch) begin
        if (mem_rsp_valid) begin
          m_wait = 0;
          m_w[m_k] = mem_rsp_data;
          if (m_k == 3) begin
            m_src = m_w[0]; m_dst = m_w[1]; m_llp = m_w[2]; m_ctl = m_w[3];
            m_fetch = 0;
          end else m_k++;
        end else if (mem_req_valid && mem_req_ready) m_wait = 1;
      end
      if (src_tran) setv |= 5'b00100;
      if (dst_tran) setv |= 5'b01000;
      if (wr_en) begin
        case (wr_sel)
          3'd0: if (!en0) begin m_src = wr_data; m_isrc = wr_data; end
          3'd1: if (!en0) begin m_dst = wr_data; m_idst = wr_data; end
          3'd2: if (!en0) m_ctl = wr_data;
          3'd3: m_cfg = wr_data[1:0];
          3'd4: if (!en0) m_llp = wr_data;
          3'd5: if (!en0 && wr_data[0]) m_en = 1;
          3'd6: clrv = wr_data[4:0];
          default: m_mask = wr_data[4:0];
        endcase
      end
      m_raw = (m_raw & ~clrv) | setv;
    end
  end

  task automatic cmp(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s %s: got %h expected %h at %0t", tag, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      cmp(cur_req, "ch_en", 32'(ch_en), 32'(m_en));
      cmp(cur_req, "cur_src", cur_src, m_src);
      cmp(cur_req, "cur_dst", cur_dst, m_dst);
      cmp(cur_req, "cur_ctl", cur_ctl, m_ctl);
      cmp(cur_req, "cur_llp", cur_llp, m_llp);
      cmp(cur_req, "int_raw", 32'(int_raw), 32'(m_raw));
      cmp(cur_req, "int_stat R10", 32'(int_stat), 32'(m_raw & m_mask));
      cmp(cur_req, "irq R10", 32'(irq), 32'(|(m_raw & m_mask)));
      cmp(cur_req, "req_valid R7", 32'(mem_req_valid), 32'(m_fetch && !m_wait));
      if (mem_req_valid) cmp(cur_req, "req_addr R6", mem_req_addr, m_base + 32'(4 * m_k));
    end
  end

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    wr_en = 1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic bdone(input logic [31:0] se, input logic [31:0] de);
    blk_done = 1; blk_src_end = se; blk_dst_end = de;
    @(negedge clk);
    blk_done = 0;
  endtask

  task automatic wait_fetch();
    int n = 0;
    while (m_fetch && n < 100) begin @(negedge clk); n++; end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 32'h0;
    mem[4] = 32'h0000_A000; mem[5] = 32'h0000_B000; mem[6] = 32'h0000_0021; mem[7] = 32'h0000_000C;
    mem[8] = 32'h0000_A100; mem[9] = 32'h0000_B100; mem[10] = 32'h0000_0030; mem[11] = 32'h0000_0000;

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    cmp("R1", "ch_en", 32'(ch_en), 0);
    cmp("R1", "cur_src", cur_src, 0);
    cmp("R1", "int_raw", 32'(int_raw), 0);
    cmp("R1", "irq", 32'(irq), 0);
    cmp("R1", "req_valid", 32'(mem_req_valid), 0);

    // R2 programming and lock
    cur_req = "R2";
    wr(3'd7, 32'h1F);
    wr(3'd0, 32'h1000); wr(3'd1, 32'h2000); wr(3'd2, 32'h0); wr(3'd4, 32'h0); wr(3'd3, 32'h0);
    wr(3'd5, 32'h1);
    wr(3'd0, 32'hDEAD_0000);
    wr(3'd4, 32'h40);
    cmp("R2", "locked src", cur_src, 32'h1000);
    cmp("R2", "locked llp", cur_llp, 32'h0);
    cmp("R2", "running", 32'(ch_en), 1);

    // R3 single block termination
    cur_req = "R3";
    bdone(32'h1100, 32'h2100);
    cmp("R3", "ch_en after end", 32'(ch_en), 0);
    cmp("R3", "tfr+blk flags", 32'(int_raw), 32'h3);
    wr(3'd6, 32'h1F);
    cmp("R3", "flags cleared", 32'(int_raw), 0);

    // R4 zero pointer (low bits only) ignores list enables
    cur_req = "R4";
    wr(3'd2, 32'hC); wr(3'd4, 32'h2); wr(3'd5, 32'h1);
    repeat (2) @(negedge clk);
    bdone(32'h0, 32'h0);
    cmp("R4", "ended without fetch", 32'(ch_en), 0);
    cmp("R4", "tfr flag", 32'(int_raw[0]), 1);
    wr(3'd6, 32'h1F);

    // R5 auto reload, source side only, then both, then stop
    cur_req = "R5";
    wr(3'd2, 32'h0); wr(3'd4, 32'h0);
    wr(3'd0, 32'h100); wr(3'd1, 32'h200); wr(3'd3, 32'h1); wr(3'd5, 32'h1);
    bdone(32'h140, 32'h240);
    cmp("R5", "src reloaded", cur_src, 32'h100);
    cmp("R5", "dst continues", cur_dst, 32'h240);
    cmp("R5", "still running", 32'(ch_en), 1);
    bdone(32'h130, 32'h280);
    cmp("R5", "dst continues 2", cur_dst, 32'h280);
    wr(3'd3, 32'h3);
    bdone(32'h150, 32'h2C0);
    cmp("R5", "both reloaded src", cur_src, 32'h100);
    cmp("R5", "both reloaded dst", cur_dst, 32'h200);
    wr(3'd3, 32'h0);
    bdone(32'h160, 32'h2E0);
    cmp("R5", "stops after clear", 32'(ch_en), 0);
    cmp("R5", "tfr flag", 32'(int_raw[0]), 1);
    wr(3'd6, 32'h1F);

    // R6/R7/R8 linked list chain
    cur_req = "R6";
    wr(3'd0, 32'h1); wr(3'd1, 32'h2); wr(3'd2, 32'hC); wr(3'd4, 32'h11); wr(3'd5, 32'h1);
    bdone(32'h0, 32'h0);
    cur_req = "R7";
    bdone(32'h0, 32'h0);
    wait_fetch();
    @(negedge clk);
    cur_req = "R6";
    cmp("R6", "desc A src", cur_src, 32'hA000);
    cmp("R6", "desc A dst", cur_dst, 32'hB000);
    cmp("R6", "desc A llp", cur_llp, 32'h21);
    cmp("R7", "running after fetch", 32'(ch_en), 1);
    bdone(32'h0, 32'h0);
    wait_fetch();
    @(negedge clk);
    cmp("R6", "desc B src", cur_src, 32'hA100);
    cmp("R6", "desc B ctl", cur_ctl, 32'h0);
    cur_req = "R8";
    bdone(32'h0, 32'h0);
    cmp("R8", "last descriptor ends", 32'(ch_en), 0);
    cmp("R8", "tfr flag", 32'(int_raw[0]), 1);
    wr(3'd6, 32'h1F);

    // R9 illegal combinations
    cur_req = "R9";
    wr(3'd4, 32'h40); wr(3'd2, 32'h4); wr(3'd5, 32'h1);
    bdone(32'h0, 32'h0);
    cmp("R9", "one-side list error", 32'(int_raw), 32'h10);
    cmp("R9", "disabled", 32'(ch_en), 0);
    wr(3'd6, 32'h1F);
    wr(3'd2, 32'hC); wr(3'd3, 32'h1); wr(3'd5, 32'h1);
    bdone(32'h0, 32'h0);
    cmp("R9", "reload with list error", 32'(int_raw), 32'h10);
    wr(3'd3, 32'h0); wr(3'd6, 32'h1F);

    // R10 flags, mask, set beats clear
    cur_req = "R10";
    wr(3'd7, 32'h2);
    src_tran = 1; @(negedge clk); src_tran = 0;
    cmp("R10", "src tran flag", 32'(int_raw), 32'h4);
    cmp("R10", "masked irq low", 32'(irq), 0);
    dst_tran = 1; wr(3'd6, 32'h8); dst_tran = 0;
    cmp("R10", "set wins", 32'(int_raw[3]), 1);
    wr(3'd6, 32'hC);
    cmp("R10", "cleared", 32'(int_raw), 0);
    wr(3'd4, 32'h0); wr(3'd2, 32'h0); wr(3'd5, 32'h1);
    bdone(32'h0, 32'h0);
    cmp("R10", "irq from block flag", 32'(irq), 1);
    cmp("R10", "stat", 32'(int_stat), 32'h2);

    repeat (3) @(negedge clk);
    summary();
  end
endmodule